// File: doc/BRIEF.md
# Watchdog and Interval Timer

This block counts system clock cycles through a free-running binary prescaler and a small wrap-around counter. In interval mode it sets a sticky interrupt request flag each time the counter wraps, so software receives a periodic tick. Software can mask the request and clears the flag with a write. In watchdog mode the same counter must be restarted by software before it wraps. If it is not restarted in time, the block drives a one-cycle overflow pulse. Once watchdog mode is chosen, it stays in force until reset.

Software programs the block through three write-only registers on a simple strobe, address and data bus. Two sideband inputs report the low-power states. The light-sleep input has no effect on counting. The deep-sleep input freezes the prescaler and the counter for as long as it is held.

The control state machine has three states:
- ST_IDLE: counter held at zero.
- ST_INTERVAL: periodic interrupt.
- ST_WATCHDOG: overflow supervision.

Its transitions are:
- ST_IDLE to ST_WATCHDOG: RUN is latched (or being written) and the watchdog select bit is latched (or being written).
- ST_IDLE to ST_INTERVAL: RUN is latched (or being written) and the interval select bit is written or held at 1.
- ST_INTERVAL to ST_WATCHDOG: a mode write with the watchdog bit set.
- ST_INTERVAL to ST_IDLE: a mode write with both select bits 0.
- ST_WATCHDOG is left only by reset.

Top module: `wdt_interval_timer`

## Requirements
- R1: After reset both outputs are low, the mask is set and nothing counts. Unmasking without writing RUN produces no interrupt.
- R2: The register map is as follows. Address 0 is the mode register: bit 7 is RUN, bit 4 selects watchdog and bit 3 selects interval. Address 1 holds the clock select in bits 2:0. Address 2 is interrupt control: bit 0 is the mask, and writing 1 to bit 1 clears the flag. RUN with both select bits 0 does not count. RUN with bit 4 = 0 and bit 3 = 1 starts interval mode.
- R3: Clock select values 000, 010, 100 and 110 give a steady period of 2^11, 2^13, 2^15 and 2^17 cycles. Bit 0 is ignored, so 001 gives 2^11.
- R4: While the mask is 1 the interrupt output stays low, even with the flag set. Clearing the mask delivers a pending flag on the next cycle.
- R5: The flag stays set until a clear write. A later wrap sets it again.
- R6: In watchdog mode a wrap drives the overflow output high for exactly one cycle and raises no interrupt.
- R7: Each mode write with bit 7 = 1 restarts the counter. Writes of this kind spaced closer than the period keep the overflow low.
- R8: Once bit 4 has been written as 1, even with RUN = 0, later interval-mode writes leave the block in watchdog mode until reset.
- R9: RUN cannot be cleared by software. A mode write with bit 7 = 0 does not stop or restart counting.
- R10: The light-sleep input leaves the period unchanged. Each cycle the deep-sleep input is held lengthens the current period by exactly one cycle.
- R11: The first wrap after a RUN write comes no later than the nominal period. It comes no earlier than the nominal period minus one prescaler tap period (at most 1/128 short).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| halt_i | input | 1 | Light-sleep indication (counting continues) |
| stop_i | input | 1 | Deep-sleep indication (counting freezes) |
| irq_o | output | 1 | Interval interrupt request, flag gated by the mask |
| wdt_ovf_o | output | 1 | One-cycle watchdog overflow pulse |

## Verification
The bench measures intervals edge to edge, so a wrong tap choice or an honoured clock-select bit 0 shows up as a period off by a power of two. It bounds the first interval after RUN. A design that restarted the prescaler would still pass that bound, but one that failed to clear the counter would show a long or random first period. A deep-sleep pulse of known length must stretch exactly one period by exactly that length. A design that froze only the counter, or that also froze on light sleep, would miss that count. The bench also arms watchdog mode with RUN low and then requests interval mode: an unlatched select would raise an interrupt instead of an overflow. Finally, it writes the mode register with RUN low and expects the period to carry on unchanged.

// File: rtl/wdtim_pkg.sv
package wdtim_pkg;

    localparam int REG_AW = 2;
    localparam int REG_DW = 8;

    // register addresses
    localparam logic [REG_AW-1:0] ADDR_MODE = 2'd0;
    localparam logic [REG_AW-1:0] ADDR_CSEL = 2'd1;
    localparam logic [REG_AW-1:0] ADDR_ICTL = 2'd2;

    // bit positions inside the registers
    localparam int BIT_RUN   = 7;
    localparam int BIT_WDSEL = 4;
    localparam int BIT_IVSEL = 3;
    localparam int BIT_MASK  = 0;
    localparam int BIT_CLR   = 1;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_INTERVAL = 2'd1,
        ST_WATCHDOG = 2'd2
    } tmr_state_e;

endpackage

// File: rtl/wdtim_prescaler.sv
module wdtim_prescaler #(
    parameter int SEL_W    = 2,
    parameter int TAP_BASE = 4,
    parameter int TAP_STEP = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt_i,
    input  logic             stop_i,
    input  logic [SEL_W-1:0] sel_idx_i,
    output logic             tick_o
);
    localparam int NUM_TAPS = 2 ** SEL_W;
    localparam int PRE_W    = TAP_BASE + TAP_STEP * (NUM_TAPS - 1);

    logic [PRE_W-1:0]    pre_q;
    logic [NUM_TAPS-1:0] tap_hit;

    // Free-running divider: never cleared by software, frozen only in deep sleep.
    // Light sleep is intentionally absent from the step enable.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (!stop_i) begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // One tap per select value; a tap fires when its low bits are about to roll over.
    for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
        localparam int K = TAP_BASE + TAP_STEP * g;
        assign tap_hit[g] = &pre_q[K-1:0];
    end

    assign tick_o = tap_hit[sel_idx_i] & ~stop_i;

    assert_pre_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> $stable(pre_q));

    assert_halt_runs_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_i && !stop_i) |=> (pre_q != $past(pre_q)));

endmodule

// File: rtl/wdtim_counter.sv
module wdtim_counter #(
    parameter int CNT_W = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic clr_i,
    input  logic tick_i,
    output logic wrap_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en_i || clr_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // wrap fires on the tick that takes the counter from all-ones back to zero
    assign wrap_o = en_i & ~clr_i & tick_i & (&cnt_q);

    assert_cnt_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !clr_i && !tick_i) |=> $stable(cnt_q));

    assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0));

endmodule

// File: rtl/wdtim_ctrl.sv
module wdtim_ctrl
    import wdtim_pkg::*;
#(
    parameter int SEL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    input  logic              wrap_i,
    output tmr_state_e        state_o,
    output logic              cnt_clr_o,
    output logic [SEL_W-1:0]  sel_idx_o,
    output logic              irq_o,
    output logic              ovf_o
);
    tmr_state_e       state_q, state_d;
    logic             run_q, lock_q, ivsel_q;
    logic             mask_q, flag_q, ovf_q;
    logic [SEL_W-1:0] csel_q;

    logic mode_wr, csel_wr, ictl_wr;
    logic run_set, run_eff, lock_eff, ivsel_eff;
    logic unused_rsvd;

    assign mode_wr = reg_wr && (reg_addr == ADDR_MODE);
    assign csel_wr = reg_wr && (reg_addr == ADDR_CSEL);
    assign ictl_wr = reg_wr && (reg_addr == ADDR_ICTL);

    assign run_set   = mode_wr & reg_wdata[BIT_RUN];
    assign run_eff   = run_q | run_set;
    assign lock_eff  = lock_q | (mode_wr & reg_wdata[BIT_WDSEL]);
    assign ivsel_eff = mode_wr ? reg_wdata[BIT_IVSEL] : ivsel_q;

    // reserved mode bits carry no function
    assign unused_rsvd = ^reg_wdata[6:5];

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (run_eff && lock_eff) begin
                    state_d = ST_WATCHDOG;
                end else if (run_eff && ivsel_eff) begin
                    state_d = ST_INTERVAL;
                end
            end
            ST_INTERVAL: begin
                if (mode_wr && reg_wdata[BIT_WDSEL]) begin
                    state_d = ST_WATCHDOG;
                end else if (mode_wr && !reg_wdata[BIT_IVSEL]) begin
                    state_d = ST_IDLE;
                end
            end
            ST_WATCHDOG: state_d = ST_WATCHDOG;
            default:     state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // register file, flag and overflow pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            lock_q  <= 1'b0;
            ivsel_q <= 1'b0;
            csel_q  <= '0;
            mask_q  <= 1'b1;
            flag_q  <= 1'b0;
            ovf_q   <= 1'b0;
        end else begin
            if (run_set) begin
                run_q <= 1'b1;
            end
            if (mode_wr) begin
                ivsel_q <= reg_wdata[BIT_IVSEL];
                if (reg_wdata[BIT_WDSEL]) begin
                    lock_q <= 1'b1;
                end
            end
            if (csel_wr) begin
                csel_q <= reg_wdata[SEL_W:1];
            end
            if (ictl_wr) begin
                mask_q <= reg_wdata[BIT_MASK];
            end
            if (state_q == ST_INTERVAL && wrap_i) begin
                flag_q <= 1'b1;
            end else if ((ictl_wr && reg_wdata[BIT_CLR]) || state_d == ST_WATCHDOG) begin
                flag_q <= 1'b0;
            end
            ovf_q <= (state_q == ST_WATCHDOG) && wrap_i;
        end
    end

    assign state_o   = state_q;
    assign cnt_clr_o = run_set;
    assign sel_idx_o = csel_q;
    assign irq_o     = flag_q & ~mask_q;
    assign ovf_o     = ovf_q;

    assert_wd_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WATCHDOG) |=> (state_q == ST_WATCHDOG));

    assert_ovf_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |=> !ovf_q);

    assert_flag_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> ($past(state_q) == ST_INTERVAL));

    assert_run_latched_R9: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |=> run_q);

endmodule

// File: rtl/wdt_interval_timer.sv
module wdt_interval_timer #(
    parameter int CNT_W    = 7,
    parameter int SEL_W    = 2,
    parameter int TAP_BASE = 4,
    parameter int TAP_STEP = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    input  logic       halt_i,
    input  logic       stop_i,
    output logic       irq_o,
    output logic       wdt_ovf_o
);
    import wdtim_pkg::*;

    tmr_state_e       state;
    logic             cnt_clr, tick, wrap, cnt_en;
    logic [SEL_W-1:0] sel_idx;

    assign cnt_en = (state != ST_IDLE);

    wdtim_ctrl #(.SEL_W(SEL_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .wrap_i    (wrap),
        .state_o   (state),
        .cnt_clr_o (cnt_clr),
        .sel_idx_o (sel_idx),
        .irq_o     (irq_o),
        .ovf_o     (wdt_ovf_o)
    );

    wdtim_prescaler #(
        .SEL_W    (SEL_W),
        .TAP_BASE (TAP_BASE),
        .TAP_STEP (TAP_STEP)
    ) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .halt_i    (halt_i),
        .stop_i    (stop_i),
        .sel_idx_i (sel_idx),
        .tick_o    (tick)
    );

    wdtim_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (cnt_en),
        .clr_i  (cnt_clr),
        .tick_i (tick),
        .wrap_o (wrap)
    );

    assert_outputs_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_ovf_o |-> !irq_o);

endmodule

// File: tb/wdt_interval_timer_bench.sv
`timescale 1ns/1ps
module wdt_interval_timer_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic       halt_i = 1'b0;
    logic       stop_i = 1'b0;
    logic       irq_o, wdt_ovf_o;

    int cyc = 0;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc++;

    wdt_interval_timer u_wdt_interval_timer (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .halt_i(halt_i), .stop_i(stop_i),
        .irq_o(irq_o), .wdt_ovf_o(wdt_ovf_o)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = 8'd0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; reg_wr = 1'b0; halt_i = 1'b0; stop_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_irq(input int maxc, output int t, output bit seen);
        seen = 1'b0; t = 0;
        for (int i = 0; i < maxc; i++) begin
            @(negedge clk);
            if (irq_o) begin seen = 1'b1; t = cyc; break; end
        end
    endtask

    task automatic count_ovf(input int n, output int hits, output int irqs);
        hits = 0; irqs = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (wdt_ovf_o) hits++;
            if (irq_o) irqs++;
        end
    endtask

    task automatic t_reset();
        int t; bit s;
        do_reset();
        chk(irq_o == 1'b0, "R1 irq after reset", irq_o, 0);
        chk(wdt_ovf_o == 1'b0, "R1 ovf after reset", wdt_ovf_o, 0);
        wr(2'd2, 8'h00);
        wait_irq(3000, t, s);
        chk(!s, "R1 no counting without RUN", s, 0);
    endtask

    task automatic t_mode_idle();
        int t, e; bit s;
        do_reset();
        wr(2'd1, 8'h00); wr(2'd2, 8'h00);
        wr(2'd0, 8'h80);
        wait_irq(3000, t, s);
        chk(!s, "R2 RUN with mode 00 idle", s, 0);
        wr(2'd0, 8'h88); e = cyc;
        wait_irq(2100, t, s);
        chk(s && (t - e) <= 2049, "R2 interval mode starts", t - e, 2048);
    endtask

    task automatic t_period(input logic [7:0] sel, input int p, input int k, input string tag);
        int e, t1, t2; bit s;
        do_reset();
        wr(2'd1, sel); wr(2'd2, 8'h00);
        wr(2'd0, 8'h88); e = cyc;
        wait_irq(p + 10, t1, s);
        chk(s && (t1 - e) >= p - (1 << k) && (t1 - e) <= p + 1,
            {"R11 first interval ", tag}, t1 - e, p);
        wr(2'd2, 8'h02);
        wait_irq(p + 10, t2, s);
        chk(s && (t2 - t1) == p, {"R3 period ", tag}, t2 - t1, p);
    endtask

    task automatic t_mask();
        int t; bit s;
        do_reset();
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h88);
        wait_irq(2200, t, s);
        chk(!s, "R4 masked request not delivered", s, 0);
        wr(2'd2, 8'h00);
        chk(irq_o == 1'b1, "R4 pending delivered on unmask", irq_o, 1);
        repeat (500) @(negedge clk);
        chk(irq_o == 1'b1, "R5 flag sticky", irq_o, 1);
        wr(2'd2, 8'h02);
        chk(irq_o == 1'b0, "R5 flag cleared by write", irq_o, 0);
        wait_irq(2100, t, s);
        chk(s, "R5 next wrap sets flag again", s, 1);
    endtask

    task automatic t_sleep();
        int t1, t2, t3, t4; bit s;
        do_reset();
        wr(2'd1, 8'h00); wr(2'd2, 8'h00);
        wr(2'd0, 8'h88);
        wait_irq(2100, t1, s);
        wr(2'd2, 8'h02);
        halt_i = 1'b1;
        wait_irq(2100, t2, s);
        chk(s && (t2 - t1) == 2048, "R10 light sleep keeps period", t2 - t1, 2048);
        halt_i = 1'b0;
        wr(2'd2, 8'h02);
        repeat (500) @(negedge clk);
        stop_i = 1'b1;
        repeat (300) @(negedge clk);
        stop_i = 1'b0;
        wait_irq(2100, t3, s);
        chk(s && (t3 - t2) == 2348, "R10 deep sleep stretches period", t3 - t2, 2348);
        wr(2'd2, 8'h02);
        wr(2'd0, 8'h08);
        wait_irq(2100, t4, s);
        chk(s && (t4 - t3) == 2048, "R9 RUN=0 write keeps counting", t4 - t3, 2048);
    endtask

    task automatic t_watchdog();
        int hits, irqs;
        do_reset();
        wr(2'd1, 8'h00); wr(2'd2, 8'h00);
        wr(2'd0, 8'h90);
        hits = 0;
        for (int i = 0; i < 2100; i++) begin
            @(negedge clk);
            if (wdt_ovf_o) begin hits = 1; break; end
        end
        chk(hits == 1, "R6 overflow raised", hits, 1);
        @(negedge clk);
        chk(wdt_ovf_o == 1'b0, "R6 overflow lasts one cycle", wdt_ovf_o, 0);
        count_ovf(2100, hits, irqs);
        chk(irqs == 0, "R6 no interrupt in watchdog mode", irqs, 0);
    endtask

    task automatic t_kick();
        int hits, irqs, total;
        do_reset();
        wr(2'd1, 8'h00); wr(2'd2, 8'h00);
        wr(2'd0, 8'h90);
        total = 0;
        for (int i = 0; i < 5; i++) begin
            count_ovf(1500, hits, irqs);
            total += hits;
            wr(2'd0, 8'h90);
        end
        chk(total == 0, "R7 restarts hold off overflow", total, 0);
        count_ovf(2100, hits, irqs);
        chk(hits == 1, "R7 overflow after restarts stop", hits, 1);
    endtask

    task automatic t_lock();
        int hits, irqs;
        do_reset();
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h10);
        wr(2'd2, 8'h00);
        wr(2'd0, 8'h88);
        count_ovf(2100, hits, irqs);
        chk(hits == 1 && irqs == 0, "R8 interval request ignored after lock", hits, 1);
        wr(2'd0, 8'h88);
        count_ovf(2100, hits, irqs);
        chk(irqs == 0, "R8 still no interrupt", irqs, 0);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_mode_idle();
        t_period(8'h00, 2048, 4, "sel 000");
        t_period(8'h02, 8192, 6, "sel 010");
        t_period(8'h04, 32768, 8, "sel 100");
        t_period(8'h01, 2048, 4, "sel 001");
        t_mask();
        t_sleep();
        t_watchdog();
        t_kick();
        t_lock();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule